// File: doc/BRIEF.md
# Reorder-Buffer Destination Lookup Filter

This block tracks which in-flight instructions of a two-issue core will write which architectural register. All registers live in one 128-entry index space. Integer registers take the low indices, and floating-point register fN is addressed as index N+32, so both kinds of destination go through the same tracker. Each reorder-buffer slot records the destination index of its instruction. Two dispatch ports allocate slots in program order, one commit port retires the oldest slot, and a flush input discards everything.

Two source-operand lookup ports ask whether a pending producer exists for a register and, if so, which slot holds it. Before any associative comparison, a lookup reads a one-bit-per-register presence map. The slot comparators of a port are enabled only when that register's presence bit is set, so lookups of registers with no pending writer spend no comparator activity.

Commit clears a presence bit only when the retiring slot is the most recent one allocated to that register. A small side table holds that most recent slot for each register. The queue occupancy is tracked by a three-state controller:
- ST_EMPTY: no slots are in use.
- ST_OPEN: at least two slots are free.
- ST_TIGHT: fewer than two slots are free, and dispatch is stalled.

The transitions are:
- first-dispatch: ST_EMPTY to ST_OPEN.
- drain: ST_OPEN to ST_EMPTY, when the last slot retires.
- fill: ST_OPEN to ST_TIGHT.
- relieve: ST_TIGHT to ST_OPEN.
- flush: any state to ST_EMPTY.

Top module: `rob_dest_filter`

## Requirements
- R1: Every 7-bit register index 0..127 is tracked the same way, including floating-point indices 32..127 (fN at N+32) and the top index 127.
- R2: A dispatch port is accepted when its valid input and disp_ready are both high. d0_slot always shows the tail slot. d1_slot shows tail+1 when d0_valid is high and the tail slot otherwise. Accepted instructions occupy those slots in that order.
- R3: qN_hit is 1 exactly when an in-flight slot targets qN_reg, and qN_slot then gives that slot number.
- R4: When several in-flight slots target the same register, a lookup returns the youngest one, meaning the most recently allocated.
- R5: q1 is the source port of the second instruction of the pair. If d0 is accepted in the same cycle and d0_dest equals q1_reg, q1 reports a hit on d0_slot. q0 does not see d0 or d1 of the same cycle, and q1 does not see d1.
- R6: qN_srch is 1 exactly when, at the start of the cycle, some in-flight slot targets qN_reg. When it is 0, the slot comparators of that port are idle and the port reports no stored producer.
- R7: A high cm_valid retires the oldest slot. The register's presence bit clears only if no younger in-flight slot targets the same register.
- R8: If a register is allocated and its last producer commits in the same cycle, the presence bit stays set.
- R9: disp_ready is 0 when fewer than two slots are free. Dispatch requests are then ignored, so the slots and the tail do not move.
- R10: cm_valid while the buffer is empty has no effect.
- R11: flush empties the buffer and clears all presence bits in one cycle, overriding any dispatch or commit in that cycle.
- R12: rob_empty is 1 exactly when no slot is in use, and it is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all in-flight slots |
| d0_valid | input | 1 | First dispatch request |
| d0_dest | input | 7 | First instruction destination index |
| d1_valid | input | 1 | Second dispatch request |
| d1_dest | input | 7 | Second instruction destination index |
| disp_ready | output | 1 | At least two slots free |
| d0_slot | output | 4 | Slot for first instruction |
| d1_slot | output | 4 | Slot for second instruction |
| q0_reg | input | 7 | Lookup register, first instruction source |
| q0_srch | output | 1 | Presence bit; comparators enabled |
| q0_hit | output | 1 | Pending producer exists |
| q0_slot | output | 4 | Youngest producer slot |
| q1_reg | input | 7 | Lookup register, second instruction source |
| q1_srch | output | 1 | Presence bit; comparators enabled |
| q1_hit | output | 1 | Pending producer exists (incl. same-cycle d0) |
| q1_slot | output | 4 | Youngest producer slot |
| cm_valid | input | 1 | Retire the oldest slot |
| rob_empty | output | 1 | No slot in use |

## Verification
The checker watches several properties on every cycle:
- a cleared presence bit never yields a stored hit;
- the same-cycle pairing bypass reports d0_slot;
- the tail holds still while dispatch is stalled;
- flush leaves an empty buffer with a clear map;
- an idle empty buffer stays empty;
- paired slots are consecutive.

Youngest-match selection, the rule that commit clears a presence bit only for the most recent producer, and the priority of allocation over commit can only be shown by the bench's scenarios. The bench compares against an in-order reference model of the slot contents.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_OPEN  = 2'd1,
        ST_TIGHT = 2'd2
    } occ_state_t;
endpackage

// File: rtl/rdf_queue_ctrl.sv
module rdf_queue_ctrl
    import rdf_pkg::*;
#(
    parameter int NSLOT = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     alloc0,
    input  logic                     alloc1,
    input  logic                     commit_req,
    output logic [$clog2(NSLOT)-1:0] head,
    output logic [$clog2(NSLOT)-1:0] tail,
    output logic                     ready,
    output logic                     empty,
    output logic                     commit_ok
);
    localparam int SW = $clog2(NSLOT);
    localparam int CW = SW + 1;
    localparam logic [CW-1:0] TIGHT_AT = CW'(NSLOT - 1);

    occ_state_t      st, st_nx;
    logic [CW-1:0]   count, count_nx, n_alloc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || flush) st <= ST_EMPTY;
        else                 st <= st_nx;
    end

    // outputs
    always_comb begin
        ready     = 1'b1;
        empty     = 1'b0;
        unique case (st)
            ST_EMPTY: empty = 1'b1;
            ST_OPEN:  ready = 1'b1;
            ST_TIGHT: ready = 1'b0;
            default:  ready = 1'b0;
        endcase
        commit_ok = commit_req && !empty;
    end

    always_comb begin
        n_alloc  = CW'(alloc0) + CW'(alloc1);
        count_nx = count + n_alloc - CW'(commit_ok);
    end

    // transitions: first-dispatch, drain, fill, relieve
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_EMPTY: if (count_nx != '0) st_nx = ST_OPEN;
            ST_OPEN: begin
                if (count_nx == '0)            st_nx = ST_EMPTY;
                else if (count_nx >= TIGHT_AT) st_nx = ST_TIGHT;
            end
            ST_TIGHT: if (count_nx < TIGHT_AT) st_nx = ST_OPEN;
            default:  st_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            count <= '0;
            head  <= '0;
            tail  <= '0;
        end else begin
            count <= count_nx;
            head  <= head + SW'(commit_ok);
            tail  <= tail + n_alloc[SW-1:0];
        end
    end
endmodule

// File: rtl/rdf_presence.sv
module rdf_presence #(
    parameter int NREG  = 128,
    parameter int NSLOT = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     set0,
    input  logic [$clog2(NREG)-1:0]  set0_reg,
    input  logic [$clog2(NSLOT)-1:0] set0_slot,
    input  logic                     set1,
    input  logic [$clog2(NREG)-1:0]  set1_reg,
    input  logic [$clog2(NSLOT)-1:0] set1_slot,
    input  logic                     clr,
    input  logic [$clog2(NREG)-1:0]  clr_reg,
    input  logic [$clog2(NSLOT)-1:0] clr_slot,
    input  logic [$clog2(NREG)-1:0]  rd0_reg,
    input  logic [$clog2(NREG)-1:0]  rd1_reg,
    output logic                     rd0_bit,
    output logic                     rd1_bit
);
    localparam int SW = $clog2(NSLOT);

    logic [NREG-1:0] bits;
    logic [SW-1:0]   latest [NREG];

    // most recent slot allocated to each register; second port wins
    always_ff @(posedge clk) begin
        if (set0) latest[set0_reg] <= set0_slot;
        if (set1) latest[set1_reg] <= set1_slot;
    end

    // clear first, so a same-cycle allocation keeps the bit set
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            bits <= '0;
        end else begin
            if (clr && latest[clr_reg] == clr_slot) bits[clr_reg] <= 1'b0;
            if (set0) bits[set0_reg] <= 1'b1;
            if (set1) bits[set1_reg] <= 1'b1;
        end
    end

    assign rd0_bit = bits[rd0_reg];
    assign rd1_bit = bits[rd1_reg];
endmodule

// File: rtl/rdf_entries.sv
module rdf_entries #(
    parameter int NREG  = 128,
    parameter int NSLOT = 16
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       flush,
    input  logic                                       w0,
    input  logic [$clog2(NSLOT)-1:0]                   w0_slot,
    input  logic [$clog2(NREG)-1:0]                    w0_reg,
    input  logic                                       w1,
    input  logic [$clog2(NSLOT)-1:0]                   w1_slot,
    input  logic [$clog2(NREG)-1:0]                    w1_reg,
    input  logic                                       ret,
    input  logic [$clog2(NSLOT)-1:0]                   ret_slot,
    output logic [NSLOT-1:0]                           valid,
    output logic [NSLOT-1:0][$clog2(NREG)-1:0]         dest
);
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid <= '0;
        end else begin
            if (ret) valid[ret_slot] <= 1'b0;
            if (w0)  valid[w0_slot]  <= 1'b1;
            if (w1)  valid[w1_slot]  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (w0) dest[w0_slot] <= w0_reg;
        if (w1) dest[w1_slot] <= w1_reg;
    end
endmodule

// File: rtl/rdf_match.sv
module rdf_match #(
    parameter int NREG  = 128,
    parameter int NSLOT = 16
) (
    input  logic                               en,
    input  logic [$clog2(NREG)-1:0]            key,
    input  logic [$clog2(NSLOT)-1:0]           head,
    input  logic [NSLOT-1:0]                   valid,
    input  logic [NSLOT-1:0][$clog2(NREG)-1:0] dest,
    output logic                               hit,
    output logic [$clog2(NSLOT)-1:0]           slot
);
    localparam int SW = $clog2(NSLOT);

    logic [NSLOT-1:0] mline;
    logic [SW-1:0]    idx;

    // match lines, all held low unless the presence bit enables them
    for (genvar i = 0; i < NSLOT; i++) begin : g_line
        assign mline[i] = en && valid[i] && (dest[i] == key);
    end

    // walk oldest to youngest; the last match found is the youngest
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        idx  = '0;
        for (int k = 0; k < NSLOT; k++) begin
            idx = head + SW'(k);
            if (mline[idx]) begin
                hit  = 1'b1;
                slot = idx;
            end
        end
    end
endmodule

// File: rtl/rob_dest_filter.sv
module rob_dest_filter #(
    parameter int NREG  = 128,
    parameter int NSLOT = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     d0_valid,
    input  logic [$clog2(NREG)-1:0]  d0_dest,
    input  logic                     d1_valid,
    input  logic [$clog2(NREG)-1:0]  d1_dest,
    output logic                     disp_ready,
    output logic [$clog2(NSLOT)-1:0] d0_slot,
    output logic [$clog2(NSLOT)-1:0] d1_slot,
    input  logic [$clog2(NREG)-1:0]  q0_reg,
    output logic                     q0_srch,
    output logic                     q0_hit,
    output logic [$clog2(NSLOT)-1:0] q0_slot,
    input  logic [$clog2(NREG)-1:0]  q1_reg,
    output logic                     q1_srch,
    output logic                     q1_hit,
    output logic [$clog2(NSLOT)-1:0] q1_slot,
    input  logic                     cm_valid,
    output logic                     rob_empty
);
    localparam int SW = $clog2(NSLOT);
    localparam int RW = $clog2(NREG);

    logic                         acc0, acc1, commit_ok;
    logic [SW-1:0]                head, tail;
    logic [NSLOT-1:0]             valid;
    logic [NSLOT-1:0][RW-1:0]     dest;
    logic [1:0][RW-1:0]           qreg;
    logic [1:0]                   srch, m_hit;
    logic [1:0][SW-1:0]           m_slot;
    logic                         byp;

    assign acc0    = d0_valid && disp_ready;
    assign acc1    = d1_valid && disp_ready;
    assign d0_slot = tail;
    assign d1_slot = tail + {{(SW-1){1'b0}}, d0_valid};

    rdf_queue_ctrl #(.NSLOT(NSLOT)) u_qctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc0(acc0), .alloc1(acc1), .commit_req(cm_valid),
        .head(head), .tail(tail), .ready(disp_ready),
        .empty(rob_empty), .commit_ok(commit_ok)
    );

    rdf_entries #(.NREG(NREG), .NSLOT(NSLOT)) u_entries (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .w0(acc0), .w0_slot(d0_slot), .w0_reg(d0_dest),
        .w1(acc1), .w1_slot(d1_slot), .w1_reg(d1_dest),
        .ret(commit_ok), .ret_slot(head),
        .valid(valid), .dest(dest)
    );

    rdf_presence #(.NREG(NREG), .NSLOT(NSLOT)) u_presence (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .set0(acc0), .set0_reg(d0_dest), .set0_slot(d0_slot),
        .set1(acc1), .set1_reg(d1_dest), .set1_slot(d1_slot),
        .clr(commit_ok), .clr_reg(dest[head]), .clr_slot(head),
        .rd0_reg(q0_reg), .rd1_reg(q1_reg),
        .rd0_bit(srch[0]), .rd1_bit(srch[1])
    );

    assign qreg = {q1_reg, q0_reg};

    for (genvar p = 0; p < 2; p++) begin : g_port
        rdf_match #(.NREG(NREG), .NSLOT(NSLOT)) u_match (
            .en(srch[p]), .key(qreg[p]), .head(head),
            .valid(valid), .dest(dest),
            .hit(m_hit[p]), .slot(m_slot[p])
        );
    end

    // same-cycle pairing: first instruction is younger than anything stored
    assign byp     = acc0 && (d0_dest == q1_reg);
    assign q0_srch = srch[0];
    assign q1_srch = srch[1];
    assign q0_hit  = m_hit[0];
    assign q0_slot = m_slot[0];
    assign q1_hit  = byp || m_hit[1];
    assign q1_slot = byp ? d0_slot : m_slot[1];
endmodule

// File: rtl/rob_dest_filter_chk.sv
module rob_dest_filter_chk #(
    parameter int NREG  = 128,
    parameter int NSLOT = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     flush,
    input logic                     d0_valid,
    input logic [$clog2(NREG)-1:0]  d0_dest,
    input logic                     d1_valid,
    input logic                     disp_ready,
    input logic [$clog2(NSLOT)-1:0] d0_slot,
    input logic [$clog2(NSLOT)-1:0] d1_slot,
    input logic                     q0_srch,
    input logic                     q0_hit,
    input logic [$clog2(NREG)-1:0]  q1_reg,
    input logic                     q1_srch,
    input logic                     q1_hit,
    input logic [$clog2(NSLOT)-1:0] q1_slot,
    input logic                     rob_empty
);
    AST_MISS_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !q0_srch |-> !q0_hit); // R6
    AST_PAIR_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_valid && disp_ready && d0_dest == q1_reg) |-> (q1_hit && q1_slot == d0_slot)); // R5
    AST_STALL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ready && !flush) |=> (d0_slot == $past(d0_slot))); // R9
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rob_empty && !q0_srch && !q1_srch && disp_ready)); // R11
    AST_EMPTY_NO_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        rob_empty |-> (!q0_srch && !q1_srch)); // R12
    AST_IDLE_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rob_empty && !d0_valid && !d1_valid) |=> rob_empty); // R10
    AST_PAIR_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        d0_valid |-> (d1_slot == d0_slot + 1'b1)); // R2
endmodule

bind rob_dest_filter rob_dest_filter_chk #(.NREG(NREG), .NSLOT(NSLOT)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .d0_valid(d0_valid), .d0_dest(d0_dest), .d1_valid(d1_valid),
    .disp_ready(disp_ready), .d0_slot(d0_slot), .d1_slot(d1_slot),
    .q0_srch(q0_srch), .q0_hit(q0_hit),
    .q1_reg(q1_reg), .q1_srch(q1_srch), .q1_hit(q1_hit), .q1_slot(q1_slot),
    .rob_empty(rob_empty)
);

// File: tb/rob_dest_filter_bench.sv
module rob_dest_filter_bench;
    localparam int NREG  = 128;
    localparam int NSLOT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       d0_valid = 1'b0, d1_valid = 1'b0, cm_valid = 1'b0;
    logic [6:0] d0_dest = '0, d1_dest = '0, q0_reg = '0, q1_reg = '0;
    logic       disp_ready, q0_srch, q0_hit, q1_srch, q1_hit, rob_empty;
    logic [3:0] d0_slot, d1_slot, q0_slot, q1_slot;

    always #5 clk = ~clk; // 100 MHz

    rob_dest_filter #(.NREG(NREG), .NSLOT(NSLOT)) u_rob_dest_filter (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .d0_valid(d0_valid), .d0_dest(d0_dest),
        .d1_valid(d1_valid), .d1_dest(d1_dest),
        .disp_ready(disp_ready), .d0_slot(d0_slot), .d1_slot(d1_slot),
        .q0_reg(q0_reg), .q0_srch(q0_srch), .q0_hit(q0_hit), .q0_slot(q0_slot),
        .q1_reg(q1_reg), .q1_srch(q1_srch), .q1_hit(q1_hit), .q1_slot(q1_slot),
        .cm_valid(cm_valid), .rob_empty(rob_empty)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model: in-order list of slot contents
    bit ref_v [NSLOT];
    int ref_d [NSLOT];
    int head = 0, tail = 0, cnt = 0;

    typedef struct {
        bit rdy; int s0; int s1; bit emp;
        bit e0; bit h0; int k0;
        bit e1; bit h1; int k1;
        string tag;
    } exp_t;
    exp_t sb [$];

    task automatic chk(bit ok, string req, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s [%s] act=%0d exp=%0d", req, tag, act, expv);
        end
    endtask

    function automatic bit present(int r);
        for (int i = 0; i < NSLOT; i++) if (ref_v[i] && ref_d[i] == r) return 1;
        return 0;
    endfunction

    // youngest stored producer: search from newest to oldest
    function automatic void look(int r, output bit h, output int s);
        h = 0; s = 0;
        for (int k = cnt - 1; k >= 0; k--) begin
            int i = (head + k) % NSLOT;
            if (ref_v[i] && ref_d[i] == r) begin h = 1; s = i; return; end
        end
    endfunction

    // driver: apply one cycle of stimulus, push expected results, advance model
    task automatic step(bit v0, int r0, bit v1, int r1, int a0, int a1,
                        bit cm, bit fl, string tag);
        exp_t e;
        @(negedge clk); #1;
        d0_valid = v0; d0_dest = 7'(r0); d1_valid = v1; d1_dest = 7'(r1);
        q0_reg = 7'(a0); q1_reg = 7'(a1); cm_valid = cm; flush = fl;
        e.tag = tag;
        e.rdy = (NSLOT - cnt) >= 2;
        e.s0  = tail;
        e.s1  = (tail + (v0 ? 1 : 0)) % NSLOT;
        e.emp = (cnt == 0);
        e.e0  = present(a0);
        e.e1  = present(a1);
        look(a0, e.h0, e.k0);
        if (v0 && e.rdy && r0 == a1) begin e.h1 = 1; e.k1 = tail; end
        else look(a1, e.h1, e.k1);
        sb.push_back(e);
        if (fl) begin
            for (int i = 0; i < NSLOT; i++) ref_v[i] = 0;
            head = 0; tail = 0; cnt = 0;
        end else begin
            if (cm && cnt > 0) begin ref_v[head] = 0; head = (head + 1) % NSLOT; cnt--; end
            if (e.rdy && v0) begin ref_v[tail] = 1; ref_d[tail] = r0; tail = (tail + 1) % NSLOT; cnt++; end
            if (e.rdy && v1) begin ref_v[tail] = 1; ref_d[tail] = r1; tail = (tail + 1) % NSLOT; cnt++; end
        end
    endtask

    // monitor: compare combinational outputs late in the low phase
    initial begin
        exp_t e;
        forever begin
            @(negedge clk); #3;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk(disp_ready == e.rdy, "R9 ready", e.tag, disp_ready, e.rdy);
                chk(d0_slot == e.s0, "R2 d0_slot", e.tag, d0_slot, e.s0);
                chk(d1_slot == e.s1, "R2 d1_slot", e.tag, d1_slot, e.s1);
                chk(rob_empty == e.emp, "R12 empty", e.tag, rob_empty, e.emp);
                chk(q0_srch == e.e0, "R6 q0_srch", e.tag, q0_srch, e.e0);
                chk(q1_srch == e.e1, "R6 q1_srch", e.tag, q1_srch, e.e1);
                chk(q0_hit == e.h0, "R3 q0_hit", e.tag, q0_hit, e.h0);
                chk(q1_hit == e.h1, "R3/R5 q1_hit", e.tag, q1_hit, e.h1);
                if (e.h0) chk(q0_slot == e.k0, "R4 q0_slot", e.tag, q0_slot, e.k0);
                if (e.h1) chk(q1_slot == e.k1, "R4 q1_slot", e.tag, q1_slot, e.k1);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSLOT; i++) begin ref_v[i] = 0; ref_d[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #3;
        chk(rob_empty == 1'b1, "R12 reset", "reset", rob_empty, 1);
        chk(disp_ready == 1'b1, "R9 reset", "reset", disp_ready, 1);
        chk(q0_srch == 1'b0, "R6 reset", "reset", q0_srch, 0);

        // R1: floating-point index f1 -> 33 and the top index 127
        step(1, 33, 1, 5, 0, 0, 0, 0, "R1 dispatch");
        step(1, 127, 0, 0, 33, 5, 0, 0, "R1 fp lookup");
        step(0, 0, 0, 0, 127, 1, 0, 0, "R1 top index");
        // R4: repeated destinations, youngest wins
        step(1, 9, 1, 9, 9, 9, 0, 0, "R4 dup pair");
        step(1, 9, 0, 0, 9, 33, 0, 0, "R4 dup third");
        step(0, 0, 0, 0, 9, 9, 0, 0, "R4 youngest");
        // R5: same-cycle pairing bypass
        step(1, 40, 1, 41, 40, 40, 0, 0, "R5 q1 sees d0");
        step(1, 50, 1, 51, 51, 51, 0, 0, "R5 q1 not d1");
        // R7: in-order commit, bit kept while a younger producer exists
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 9, 33, 1, 0, "R7 commit");
        step(0, 0, 0, 0, 9, 40, 0, 0, "R7 after");
        // R9: fill until stalled, keep requesting
        for (int i = 0; i < 10; i++) step(1, 60 + i, 1, 90 + i, 60, 127, 0, 0, "R9 fill");
        step(0, 0, 0, 0, 70, 99, 1, 0, "R9 stalled commit");
        // R11: flush overrides dispatch and commit
        step(1, 3, 1, 4, 60, 3, 1, 1, "R11 flush");
        step(0, 0, 0, 0, 60, 3, 0, 0, "R11 after");
        // R10: commit on empty
        step(0, 0, 0, 0, 3, 4, 1, 0, "R10 empty commit");
        step(0, 0, 0, 0, 3, 4, 0, 0, "R10 after");
        // R8: allocate and commit the same register together
        step(1, 70, 0, 0, 70, 70, 0, 0, "R8 setup");
        step(1, 70, 0, 0, 70, 70, 1, 0, "R8 alloc+commit");
        step(0, 0, 0, 0, 70, 70, 0, 0, "R8 bit kept");
        step(0, 0, 0, 0, 70, 70, 1, 0, "R8 drain");
        step(0, 0, 0, 0, 70, 70, 0, 0, "R8 cleared");

        // mixed traffic over a small register set to force duplicates
        for (int i = 0; i < 600; i++) begin
            int r0 = $urandom_range(0, 5) + (($urandom_range(0, 1) == 1) ? 32 : 0);
            int r1 = $urandom_range(0, 5) + (($urandom_range(0, 1) == 1) ? 32 : 0);
            int a0 = $urandom_range(0, 5) + (($urandom_range(0, 1) == 1) ? 32 : 0);
            int a1 = $urandom_range(0, 5) + (($urandom_range(0, 1) == 1) ? 32 : 0);
            step($urandom_range(0, 2) != 0, r0, $urandom_range(0, 1) == 1, r1, a0, a1,
                 $urandom_range(0, 2) != 0, $urandom_range(0, 60) == 0, "mixed");
        end

        @(negedge clk); #1;
        d0_valid = 0; d1_valid = 0; cm_valid = 0; flush = 0;
        wait (sb.size() == 0);
        @(negedge clk); #5;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule